// File: doc/BRIEF.md
# Asynchronous Bus Cycle Controller

This block is a bus master. It runs single read and write transfers on a parallel 32-bit bus where address and data travel on separate wires. An internal client asks for a transfer through a valid/ready request port that carries the address, the write data, the direction and a fast-termination flag. The controller then drives the address, the direction line, an active-low address strobe and an active-low data strobe. In a normal cycle it adds wait states until the slave pulls the active-low acknowledge input low. That input passes through a two-flop synchronizer before the controller looks at it. When the request marks a fast-terminated region, the controller ignores the external acknowledge, supplies its own, and finishes in two clocks. In a fast write the data strobe is never asserted.

The state machine has five states, one clock each. ST_IDLE is where the controller waits for a request. ST_ADDR covers the address phase (bus states S0/S1). ST_XFER covers the transfer phase (S2/S3). ST_WAIT is the repeated wait state. ST_TERM covers termination (S4/S5). The transitions are:
- IDLE to ADDR when a request is accepted.
- ADDR to TERM for a fast cycle, or ADDR to XFER for a normal cycle.
- XFER to TERM when the synchronized acknowledge is present, otherwise XFER to WAIT.
- WAIT to WAIT while the acknowledge is still missing, then WAIT to TERM.
- TERM to IDLE unconditionally.

When the cycle ends, `done` pulses for one clock, together with the captured read data.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset, req_ready is 1, both strobes are 1 (negated), bus_dout_en is 0, done is 0 and bus_read is 1.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the acceptance edge until the cycle's strobes negate, so it is 0 in every clock in which addr_strobe_n is 0.
- R3: bus_addr equals the accepted req_addr in every clock in which addr_strobe_n is 0. In those same clocks, bus_read is 1 for a read (req_write=0) and 0 for a write (req_write=1).
- R4: In a normal cycle (req_fast=0), addr_strobe_n stays 0 until the acknowledge has passed the two-flop synchronizer. If the slave pulls bus_ack_n low in clock k of the strobe (k from 0), the strobe lasts exactly k+4 clocks.
- R5: A normal cycle always has at least one wait state, so its address strobe is never shorter than 4 clocks.
- R6: In a fast cycle (req_fast=1), addr_strobe_n is 0 for exactly 2 clocks, whatever bus_ack_n does.
- R7: data_strobe_n is 0 in these clocks:
  - Normal read: every strobed clock.
  - Normal write: every strobed clock except the first.
  - Fast read: both clocks.
  - Fast write: never.
- R8: bus_dout_en is 1 only during writes, and then bus_dout equals the accepted req_wdata. In a normal write it is 1 in every strobed clock except the first. In a fast write it is 1 in the last clock only.
- R9: done is 1 in the first clock after addr_strobe_n returns to 1. For a read, rd_data then holds the value that was on bus_din in the last strobed clock.
- R10: done is a single-clock pulse, and there is exactly one pulse per bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a transfer |
| req_ready | output | 1 | Controller is idle and can take a transfer |
| req_addr | input | 32 | Transfer address |
| req_wdata | input | 32 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fast | input | 1 | Region uses fast termination with an internal acknowledge |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Data captured by the last read |
| bus_addr | output | 32 | Bus address |
| bus_read | output | 1 | Bus direction, 1 = read |
| addr_strobe_n | output | 1 | Address strobe, active low |
| data_strobe_n | output | 1 | Data strobe, active low |
| bus_dout | output | 32 | Data driven onto the bus |
| bus_dout_en | output | 1 | Output enable for bus_dout |
| bus_din | input | 32 | Data read from the bus |
| bus_ack_n | input | 1 | Slave acknowledge, active low, asynchronous |

## Verification
The assertions assume the client leaves req_write and req_fast alone except on an accepted request. They also assume the slave keeps bus_ack_n low only while the address strobe is asserted, and releases it within half a clock of the strobe negating. Without that release, a stale synchronized acknowledge could end the next normal cycle early. The bench slave watches the strobe on every falling edge, so it raises bus_ack_n within half a clock of the strobe negating. It holds bus_din steady for the whole strobe. The driver issues a new request only after the previous done, which keeps the two-clock synchronizer tail clear of the next sampling point.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;

    // One clock per state; ST_WAIT may repeat.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,   // S0/S1
        ST_XFER = 3'd2,   // S2/S3
        ST_WAIT = 3'd3,   // inserted wait
        ST_TERM = 3'd4    // S4/S5
    } bus_state_t;

    typedef struct packed {
        logic write;
        logic fast;
    } bus_cmd_t;

endpackage

// File: rtl/bus_ack_sync.sv
module bus_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_async,
    output logic ack_seen
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= ack_n_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], ack_n_async};
            end
        end
    endgenerate

    assign ack_seen = ~chain_q[STAGES-1];

endmodule

// File: rtl/bus_fsm.sv
module bus_fsm
    import bus_cycle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  bus_cmd_t   cmd,
    input  logic       ack_seen,
    output bus_state_t state,
    output logic       idle,
    output logic       as_n,
    output logic       ds_n,
    output logic       dout_en
);

    bus_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ADDR;
            ST_ADDR: state_d = cmd.fast ? ST_TERM : ST_XFER;
            ST_XFER: state_d = ack_seen ? ST_TERM : ST_WAIT;
            ST_WAIT: state_d = ack_seen ? ST_TERM : ST_WAIT;
            ST_TERM: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        as_n    = 1'b1;
        ds_n    = 1'b1;
        dout_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                as_n = 1'b1;
            end
            ST_ADDR: begin
                as_n = 1'b0;
                ds_n = cmd.write;
            end
            ST_XFER, ST_WAIT: begin
                as_n    = 1'b0;
                ds_n    = 1'b0;
                dout_en = cmd.write;
            end
            ST_TERM: begin
                as_n    = 1'b0;
                ds_n    = cmd.fast & cmd.write;
                dout_en = cmd.write;
            end
            default: begin
                as_n = 1'b1;
            end
        endcase
    end

    assign state = state_q;
    assign idle  = (state_q == ST_IDLE);

    // R6
    fast_two_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && cmd.fast) |=> (state_q == ST_TERM) ##1 (state_q == ST_IDLE));

    // R5
    min_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && !cmd.fast) |=> (state_q == ST_XFER));

    // R4
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_XFER || state_q == ST_WAIT) && !ack_seen) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/bus_dpath.sv
module bus_dpath
    import bus_cycle_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy,
    input  logic              term,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_fast,
    input  logic [DATA_W-1:0] bus_din,
    output bus_cmd_t          cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    bus_cmd_t          cmd_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            cmd_q   <= '0;
        end else if (start) begin
            addr_q      <= req_addr;
            wdata_q     <= req_wdata;
            cmd_q.write <= req_write;
            cmd_q.fast  <= req_fast;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= term;
            if (term && !cmd_q.write) rdata_q <= bus_din;
        end
    end

    assign cmd   = cmd_q;
    assign addr  = addr_q;
    assign wdata = wdata_q;
    assign rdata = rdata_q;
    assign done  = done_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(cmd_q)));

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bus_cycle_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_fast,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_read,
    output logic              addr_strobe_n,
    output logic              data_strobe_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ack_n
);

    bus_state_t state;
    bus_cmd_t   cmd;
    logic       idle;
    logic       start;
    logic       ack_seen;

    assign start = req_valid & idle;

    bus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_n_async (bus_ack_n),
        .ack_seen    (ack_seen)
    );

    bus_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .ack_seen (ack_seen),
        .state    (state),
        .idle     (idle),
        .as_n     (addr_strobe_n),
        .ds_n     (data_strobe_n),
        .dout_en  (bus_dout_en)
    );

    bus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (!idle),
        .term      (state == ST_TERM),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_fast  (req_fast),
        .bus_din   (bus_din),
        .cmd       (cmd),
        .addr      (bus_addr),
        .wdata     (bus_dout),
        .rdata     (rd_data),
        .done      (done)
    );

    assign req_ready = idle;
    assign bus_read  = ~cmd.write;

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe_n |-> !req_ready);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !addr_strobe_n);

    // R7
    fast_wr_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_strobe_n && !bus_read) |-> !cmd.fast);

    // R8
    rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> (!bus_read && !addr_strobe_n));

    // R9
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_strobe_n) |-> done);

endmodule

// File: tb/bus_cycle_ctrl_test.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_test;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        wr;
        logic        fast;
        int          dly;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_fast = 1'b0;
    logic        done;
    logic [31:0] rd_data;
    logic [31:0] bus_addr;
    logic        bus_read;
    logic        addr_strobe_n;
    logic        data_strobe_n;
    logic [31:0] bus_dout;
    logic        bus_dout_en;
    logic [31:0] bus_din;
    logic        bus_ack_n = 1'b1;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    item_t q[$];
    int          slv_delay = 0;
    logic [31:0] slv_data = '0;
    int          slv_cnt = 0;

    always #2 clk = ~clk;

    bus_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_write(req_write), .req_fast(req_fast),
        .done(done), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_read(bus_read),
        .addr_strobe_n(addr_strobe_n), .data_strobe_n(data_strobe_n),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din), .bus_ack_n(bus_ack_n)
    );

    assign bus_din = addr_strobe_n ? 32'h0 : slv_data;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Slave: acknowledge after slv_delay strobed clocks, release once the strobe negates.
    always @(negedge clk) begin
        if (!addr_strobe_n) begin
            if (slv_cnt >= slv_delay) bus_ack_n <= 1'b0;
            slv_cnt++;
        end else begin
            slv_cnt = 0;
            bus_ack_n <= 1'b1;
        end
    end

    // Monitor
    logic  in_cyc = 1'b0;
    int    as_cnt, ds_cnt, oe_cnt;
    logic  addr_bad, rw_bad, data_bad, rdy_bad;
    item_t cur;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!addr_strobe_n) begin
                if (!in_cyc) begin
                    in_cyc = 1'b1;
                    as_cnt = 0; ds_cnt = 0; oe_cnt = 0;
                    addr_bad = 0; rw_bad = 0; data_bad = 0; rdy_bad = 0;
                    if (q.size() == 0) begin
                        compared++; mismatched++;
                        $display("FAIL R2: bus cycle with no request, actual 1 expected 0");
                    end else cur = q[0];
                end
                as_cnt++;
                if (!data_strobe_n) ds_cnt++;
                if (bus_dout_en) begin
                    oe_cnt++;
                    if (bus_dout !== cur.wdata) data_bad = 1;
                end
                if (bus_addr !== cur.addr) addr_bad = 1;
                if (bus_read !== !cur.wr) rw_bad = 1;
                if (req_ready) rdy_bad = 1;
            end else if (in_cyc) begin
                in_cyc = 1'b0;
                if (cur.fast) begin
                    check("R6 strobe length", as_cnt, 2);
                    check("R7 data strobe clocks", ds_cnt, cur.wr ? 0 : 2);
                    check("R8 drive clocks", oe_cnt, cur.wr ? 1 : 0);
                end else begin
                    check("R4 strobe length", as_cnt, cur.dly + 4);
                    check("R5 minimum length", {31'd0, as_cnt >= 4}, 1);
                    check("R7 data strobe clocks", ds_cnt, cur.wr ? cur.dly + 3 : cur.dly + 4);
                    check("R8 drive clocks", oe_cnt, cur.wr ? cur.dly + 3 : 0);
                end
                check("R3 address", {31'd0, addr_bad}, 0);
                check("R3 direction", {31'd0, rw_bad}, 0);
                check("R8 write data", {31'd0, data_bad}, 0);
                check("R2 ready while busy", {31'd0, rdy_bad}, 0);
                check("R9 done after strobe", {31'd0, done}, 1);
                if (!cur.wr) check("R9 read data", rd_data, cur.rdata);
                void'(q.pop_front());
            end else if (done) begin
                compared++; mismatched++;
                $display("FAIL R10: stray done, actual 1 expected 0");
            end
        end
    end

    task automatic run(input logic [31:0] a, input logic [31:0] wd, input logic wr,
                       input logic fast, input int dly, input logic [31:0] rd);
        item_t it;
        it.addr = a; it.wdata = wd; it.rdata = rd; it.wr = wr; it.fast = fast; it.dly = dly;
        @(negedge clk);
        slv_delay = dly;
        slv_data  = rd;
        q.push_back(it);
        req_addr = a; req_wdata = wd; req_write = wr; req_fast = fast; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = 32'hFFFF_FFFF; req_wdata = 32'h5555_5555;
        while (q.size() != 0) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected fewer cycles", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 req_ready", {31'd0, req_ready}, 1);
        check("R1 addr strobe", {31'd0, addr_strobe_n}, 1);
        check("R1 data strobe", {31'd0, data_strobe_n}, 1);
        check("R1 drive enable", {31'd0, bus_dout_en}, 0);
        check("R1 done", {31'd0, done}, 0);
        check("R1 direction", {31'd0, bus_read}, 1);

        run(32'h1000_0004, 32'h0,         1'b0, 1'b0, 0, 32'hDEAD_BEEF);
        run(32'h1000_0008, 32'hA5A5_0F0F, 1'b1, 1'b0, 0, 32'h0);
        run(32'h2000_0010, 32'h0,         1'b0, 1'b0, 3, 32'h1234_5678);
        run(32'h2000_0014, 32'hCAFE_F00D, 1'b1, 1'b0, 5, 32'h0);
        run(32'h3000_0000, 32'h0,         1'b0, 1'b1, 1000, 32'h8765_4321);
        run(32'h3000_0004, 32'h0BAD_CAFE, 1'b1, 1'b1, 1000, 32'h0);
        run(32'h3000_0008, 32'h0,         1'b0, 1'b1, 0, 32'h0F0F_F0F0);
        run(32'h4000_0000, 32'h0,         1'b0, 1'b0, 1, 32'h7777_0001);
        run(32'h3000_000C, 32'h1357_9BDF, 1'b1, 1'b1, 0, 32'h0);
        run(32'h5000_0020, 32'hFEED_FACE, 1'b1, 1'b0, 2, 32'h0);
        run(32'hFFFF_FFFC, 32'h0,         1'b0, 1'b0, 7, 32'hFFFF_FFFF);

        repeat (6) @(negedge clk);
        // R10: no further completion after the last cycle
        check("R10 idle done", {31'd0, done}, 0);
        check("R2 idle ready", {31'd0, req_ready}, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule